// File: doc/BRIEF.md
# Multi-Source Reset Controller with Cause Register

This block merges four reset requests into five separate active-low domain resets: main logic, debug, always-on standby, real-time clock and hardware watchdog. The four requests are a power-on pulse, a supply low-voltage level, an external active-low pin and a software watchdog underflow. Each request has its own reach. A full supply event resets every domain. The external pin spares debug, standby and the real-time clock. A watchdog underflow resets only main logic. Every domain reset asserts asynchronously and releases synchronously to the clock through its own synchronizer. The pulse-type sources are stretched so that a reset lasts at least sixteen cycles.

A cause register records which requests have fired since software last cleared it. The register survives pin and watchdog resets, and only a full supply event reinitialises it. Software reads it from a plain output and zeroes it with a one-cycle clear strobe.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` or `lvd_i` is high, all five domain resets are low, and they fall without waiting for a clock edge.
- R2: After the last full supply request drops, every domain reset stays low through 17 rising edges and is high after the 18th.
- R3: `pin_rst_n_i` passes through two synchronizer flops. `rst_main_n` and `rst_hwd_n` go low after the 2nd rising edge following the pin going low. `rst_dbg_n`, `rst_aon_n` and `rst_rtc_n` stay high.
- R4: After the pin returns high, `rst_main_n` and `rst_hwd_n` are still low after 3 edges and high after the 4th. A pin reset is not stretched.
- R5: A one-cycle `wdg_uf_i` pulse pulls `rst_main_n` low at once. The other four domain resets stay high.
- R6: Counting the edge that samples the watchdog pulse as the first, `rst_main_n` is still low after 17 edges and high after the 18th.
- R7: Cause bit encoding is: bit 0 for a power-on or low-voltage event, bit 1 for the pin, and bit 4 for the watchdog. All other bits read zero. After a full supply reset the register reads 0x01.
- R8: Cause bits accumulate with OR. They survive pin and watchdog resets.
- R9: A `cause_clr_i` pulse zeroes the register on the next edge. A pin or watchdog event sampled on the same edge is kept (clear plus watchdog gives 0x10).
- R10: A power-on or low-voltage event clears all earlier cause bits and leaves 0x01, asynchronously.
- R11: When sources overlap, each domain reset is the OR of every active source that reaches it. With pin and watchdog overlapping, `rst_hwd_n` follows the pin release while `rst_main_n` waits for the watchdog stretch to end.
- R12: A domain reset never releases while any source that reaches it is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_i | input | 1 | Power-on detect request, active high |
| lvd_i | input | 1 | Low-voltage detect level, active high |
| pin_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdg_uf_i | input | 1 | Software watchdog underflow, one-cycle pulse |
| cause_clr_i | input | 1 | Software clear strobe for the cause register |
| rst_main_n | output | 1 | Main logic domain reset, active low |
| rst_dbg_n | output | 1 | Debug domain reset, active low |
| rst_aon_n | output | 1 | Always-on standby domain reset, active low |
| rst_rtc_n | output | 1 | Real-time clock domain reset, active low |
| rst_hwd_n | output | 1 | Hardware watchdog domain reset, active low |
| cause_o | output | 8 | Reset cause register |

## Verification
Four properties hold on every cycle. Each domain reset is low whenever its raw request is active. No stretched pulse ends before sixteen active cycles. Debug, standby and clock resets never fall outside a full supply event. The cause register keeps its set bits unless cleared, and empties after a clear with no new event. Only the directed scenarios can show the exact release edge counts after each source. They also show that a clear and an event landing on the same edge keep the event. The cause value after a sequence of mixed events, and the staggered release of overlapping pin and watchdog resets, are likewise left to the scenarios.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int NUM_DOM = 5;
  localparam int DOM_MAIN = 0;
  localparam int DOM_DBG  = 1;
  localparam int DOM_AON  = 2;
  localparam int DOM_RTC  = 3;
  localparam int DOM_HWD  = 4;

  localparam int CAUSE_W   = 8;
  localparam int CB_SUPPLY = 0;
  localparam int CB_PIN    = 1;
  localparam int CB_WDG    = 4;

  // Domain reach of each source, one bit per domain index
  localparam logic [NUM_DOM-1:0] REACH_FULL = 5'b11111;
  localparam logic [NUM_DOM-1:0] REACH_PIN  = 5'b10001;
  localparam logic [NUM_DOM-1:0] REACH_WDG  = 5'b00001;

  function automatic logic [NUM_DOM-1:0] dom_raw(input logic full, input logic pin,
                                                 input logic wdg);
    dom_raw = ({NUM_DOM{full}} & REACH_FULL) | ({NUM_DOM{pin}} & REACH_PIN) |
              ({NUM_DOM{wdg}} & REACH_WDG);
  endfunction

  function automatic logic [CAUSE_W-1:0] cause_set(input logic pin, input logic wdg);
    logic [CAUSE_W-1:0] v;
    v = '0;
    v[CB_PIN] = pin;
    v[CB_WDG] = wdg;
    cause_set = v;
  endfunction

  function automatic logic [CAUSE_W-1:0] cause_init();
    logic [CAUSE_W-1:0] v;
    v = '0;
    v[CB_SUPPLY] = 1'b1;
    cause_init = v;
  endfunction
endpackage

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int MIN_CYC = 16,
  parameter bit LEVEL   = 1'b1
) (
  input  logic clk,
  input  logic arst,
  input  logic req,
  output logic active
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LOAD_LVL = CW'(MIN_CYC);
  localparam logic [CW-1:0] LOAD_PLS = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt;
  logic          clr_src;

  generate
    if (LEVEL) begin : g_level
      // level request: counter held full while the request is high
      assign clr_src = req | arst;
      always_ff @(posedge clk or posedge clr_src) begin
        if (clr_src)         cnt <= LOAD_LVL;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
    end else begin : g_pulse
      // pulse request: synchronous reload, cleared by the owner's reset
      assign clr_src = arst;
      always_ff @(posedge clk or posedge clr_src) begin
        if (clr_src)         cnt <= '0;
        else if (req)        cnt <= LOAD_PLS;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
      end
    end
  endgenerate

  assign active = req | (cnt != '0);

  // checker: length of each active run, counted by its own register
  logic [CW:0] run;
  always_ff @(posedge clk or posedge clr_src) begin
    if (clr_src)                           run <= '0;
    else if (!active)                      run <= '0;
    else if (run != (CW+1)'(MIN_CYC))      run <= run + 1'b1;
  end

  a_r6_min_stretch: assert property (@(posedge clk) disable iff (clr_src)
    $fell(active) |-> run >= (CW+1)'(MIN_CYC));
endmodule

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic pin_n,
  output logic pin_act
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) sh <= '1;
    else      sh <= {sh[STAGES-2:0], pin_n};
  end

  assign pin_act = ~sh[STAGES-1];
endmodule

// File: rtl/rstc_rst_sync.sv
module rstc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic raw,
  output logic rst_n
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge raw) begin
    if (raw) sh <= '0;
    else     sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh[STAGES-1];

  // R12: no release while the raw request is present
  a_r12_held_low: assert property (@(posedge clk) raw |-> !rst_n);
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
  import rstc_pkg::*;
(
  input  logic               clk,
  input  logic               full_act,
  input  logic               clr,
  input  logic [CAUSE_W-1:0] set_vec,
  output logic [CAUSE_W-1:0] cause
);
  always_ff @(posedge clk or posedge full_act) begin
    if (full_act) cause <= cause_init();
    else          cause <= (clr ? '0 : cause) | set_vec;
  end

  a_r8_sticky: assert property (@(posedge clk) disable iff (full_act)
    !clr |=> (cause & $past(cause)) == $past(cause));

  a_r9_clear: assert property (@(posedge clk) disable iff (full_act)
    (clr && set_vec == '0) |=> cause == '0);
endmodule

// File: rtl/rstc_top.sv
module rstc_top
  import rstc_pkg::*;
#(
  parameter int MIN_CYC    = 16,
  parameter int PIN_STAGES = 2,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_i,
  input  logic               lvd_i,
  input  logic               pin_rst_n_i,
  input  logic               wdg_uf_i,
  input  logic               cause_clr_i,
  output logic               rst_main_n,
  output logic               rst_dbg_n,
  output logic               rst_aon_n,
  output logic               rst_rtc_n,
  output logic               rst_hwd_n,
  output logic [CAUSE_W-1:0] cause_o
);
  logic               full_req;
  logic               full_act;
  logic               pin_act;
  logic               wdg_act;
  logic [NUM_DOM-1:0] raw_dom;
  logic [NUM_DOM-1:0] rst_n_vec;

  assign full_req = por_i | lvd_i;

  rstc_stretch #(.MIN_CYC(MIN_CYC), .LEVEL(1'b1)) u_full_str (
    .clk(clk), .arst(1'b0), .req(full_req), .active(full_act));

  rstc_stretch #(.MIN_CYC(MIN_CYC), .LEVEL(1'b0)) u_wdg_str (
    .clk(clk), .arst(full_act), .req(wdg_uf_i), .active(wdg_act));

  rstc_pin_sync #(.STAGES(PIN_STAGES)) u_pin (
    .clk(clk), .arst(full_act), .pin_n(pin_rst_n_i), .pin_act(pin_act));

  assign raw_dom = dom_raw(full_act, pin_act, wdg_act);

  generate
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      rstc_rst_sync #(.STAGES(RST_STAGES)) u_sync (
        .clk(clk), .raw(raw_dom[d]), .rst_n(rst_n_vec[d]));
    end
  endgenerate

  assign rst_main_n = rst_n_vec[DOM_MAIN];
  assign rst_dbg_n  = rst_n_vec[DOM_DBG];
  assign rst_aon_n  = rst_n_vec[DOM_AON];
  assign rst_rtc_n  = rst_n_vec[DOM_RTC];
  assign rst_hwd_n  = rst_n_vec[DOM_HWD];

  rstc_cause_reg u_cause (
    .clk(clk), .full_act(full_act), .clr(cause_clr_i),
    .set_vec(cause_set(pin_act, wdg_uf_i)), .cause(cause_o));

  // R1: a full supply event holds every domain down
  a_r1_full_all: assert property (@(posedge clk)
    full_act |-> rst_n_vec == '0);

  // R3/R5: the retained domains fall only on a full supply event
  a_r3_dbg_kept: assert property (@(posedge clk) disable iff (full_act)
    !$fell(rst_dbg_n));
  a_r3_aon_kept: assert property (@(posedge clk) disable iff (full_act)
    !$fell(rst_aon_n));
  a_r5_rtc_kept: assert property (@(posedge clk) disable iff (full_act)
    !$fell(rst_rtc_n));
endmodule

// File: tb/sim_rstc_top.sv
`timescale 1ns/1ps
module sim_rstc_top;
  logic       clk = 1'b0;
  logic       por = 1'b1, lvd = 1'b0, pin_n = 1'b1, wdg = 1'b0, clr = 1'b0;
  logic       r_main, r_dbg, r_aon, r_rtc, r_hwd;
  logic [7:0] cause;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rstc_top u0 (
    .clk(clk), .por_i(por), .lvd_i(lvd), .pin_rst_n_i(pin_n), .wdg_uf_i(wdg),
    .cause_clr_i(clr), .rst_main_n(r_main), .rst_dbg_n(r_dbg), .rst_aon_n(r_aon),
    .rst_rtc_n(r_rtc), .rst_hwd_n(r_hwd), .cause_o(cause));

  // domains packed {hwd, rtc, aon, dbg, main}; 1 = released
  function automatic logic [4:0] doms();
    return {r_hwd, r_rtc, r_aon, r_dbg, r_main};
  endfunction

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic t_power_on();
    chk("R1 held during power-on", {3'b0, doms()}, 8'h00);
    chk("R10 cause during power-on", cause, 8'h01);
    adv(3);
    por = 1'b0;
    adv(17);
    chk("R2 still held after 17 edges", {3'b0, doms()}, 8'h00);
    adv(1);
    chk("R2 released after 18 edges", {3'b0, doms()}, 8'h1F);
    chk("R7 cause after full reset", cause, 8'h01);
  endtask

  task automatic t_pin();
    clr = 1'b1; adv(1); clr = 1'b0;
    chk("R9 clear strobe", cause, 8'h00);
    pin_n = 1'b0;
    adv(1);
    chk("R3 not yet after 1 edge", {3'b0, doms()}, 8'h1F);
    adv(1);
    chk("R3 main+hwd down, others kept", {3'b0, doms()}, 8'h0E);
    adv(1);
    chk("R7 pin cause bit1", cause, 8'h02);
    pin_n = 1'b1;
    adv(3);
    chk("R4 still held after 3 edges", {3'b0, doms()}, 8'h0E);
    adv(1);
    chk("R4 released after 4 edges", {3'b0, doms()}, 8'h1F);
    chk("R8 pin cause survives", cause, 8'h02);
  endtask

  task automatic t_wdg();
    wdg = 1'b1;
    #1;
    chk("R5 main falls at once, others kept", {3'b0, doms()}, 8'h1E);
    adv(1);
    wdg = 1'b0;
    chk("R8 cause accumulates", cause, 8'h12);
    adv(16);
    chk("R6 main held after 17 edges", {3'b0, doms()}, 8'h1E);
    adv(1);
    chk("R6 main released after 18 edges", {3'b0, doms()}, 8'h1F);
    chk("R8 cause survives watchdog", cause, 8'h12);
  endtask

  task automatic t_clear_race();
    clr = 1'b1; wdg = 1'b1;
    adv(1);
    clr = 1'b0; wdg = 1'b0;
    chk("R9 event beats clear", cause, 8'h10);
    adv(18);
    chk("R6 recovered after race", {3'b0, doms()}, 8'h1F);
  endtask

  task automatic t_overlap();
    pin_n = 1'b0;
    adv(2);
    wdg = 1'b1;
    adv(1);
    wdg = 1'b0; pin_n = 1'b1;
    adv(4);
    chk("R11 hwd follows pin, main held", {3'b0, doms()}, 8'h1E);
    adv(12);
    chk("R11 main held by watchdog", {3'b0, doms()}, 8'h1E);
    adv(1);
    chk("R11 main released", {3'b0, doms()}, 8'h1F);
    chk("R7 both pin and wdg bits", cause, 8'h12);
  endtask

  task automatic t_lvd();
    lvd = 1'b1;
    #1;
    chk("R1 low-voltage drops all at once", {3'b0, doms()}, 8'h00);
    chk("R10 low-voltage resets cause", cause, 8'h01);
    adv(5);
    lvd = 1'b0;
    adv(17);
    chk("R2 low-voltage held 17 edges", {3'b0, doms()}, 8'h00);
    adv(1);
    chk("R2 low-voltage released", {3'b0, doms()}, 8'h1F);
    chk("R7 low-voltage sets bit0 only", cause, 8'h01);
  endtask

  initial begin
    #1;
    t_power_on();
    t_pin();
    t_wdg();
    t_clear_race();
    t_overlap();
    t_lvd();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog R1-timeout actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule